// File: doc/BRIEF.md
# Two-Crate Energy Sum Trigger

This block forms a crate-level energy sum every 4 ns clock cycle by adding the 32-bit sums reported by the digitizer boards in one crate. Slots that are not in use are removed through a per-board enable mask. A sum that arrives over a link from a second crate can be added to the local total. A programmable delay lines up the remote value with the local one, so that one crate can serve as the aggregator for two. All additions saturate at the largest 32-bit value.

The resulting global sum is compared against a programmable threshold. A one-cycle trigger pulse is produced on each upward crossing. After each pulse, further crossings are ignored for a programmable holdoff. The block writes every global sum into a circular history. On a trigger it keeps a fixed-length window around the triggering sample: a programmable number of samples before it, and the rest after it. The window is then frozen, and diagnostic software reads it sample by sample through an index/data port. A trigger that arrives while a window is still being filled or is held frozen is counted and not captured.

Top module: `esum_trigger`

## Requirements
- R1: `global_sum` is the sum of all enabled board sums plus the remote term. It is registered: inputs sampled at one rising edge appear on `global_sum` after that edge.
- R2: When bit i of `board_en` is 0, board i (bits 32*i+31 down to 32*i of `board_sum`) adds nothing to the sum.
- R3: Every addition saturates, so the sum never exceeds 32'hFFFFFFFF and never wraps.
- R4: With `remote_en` = 1, `remote_sum` is added after a delay of `remote_dly` cycles (0 to 15). A delay of 0 pairs the remote value with the board sums of the same cycle. With `remote_en` = 0 the remote term is zero.
- R5: `trig` is high for exactly one cycle. It is high in the cycle after a `global_sum` that is strictly greater than `threshold`, where the previous `global_sum` was not.
- R6: A `global_sum` equal to `threshold` does not trigger. A sum that stays above the threshold does not trigger again.
- R7: After a `trig` pulse, any crossing that would produce a pulse fewer than `holdoff`+1 cycles later is dropped and is not remembered.
- R8: Once `cap_done` is high, setting `rd_idx` = i returns on `rd_data`, one cycle later, the global sum at offset i − P from the triggering sample. P is `pre_depth`, clamped to WIN_LEN−1. Entry P is the triggering sample.
- R9: `cap_done` rises WIN_LEN−1−P cycles after the `trig` pulse that started the capture. It stays high until `cap_rearm` is sampled high, and falls in the next cycle.
- R10: A crossing that occurs while a capture is filling or held still pulses `trig`. It increments `miss_cnt` (saturating) and leaves the captured window unchanged.
- R11: After reset, `global_sum`, `trig`, `cap_done` and `miss_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sum clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| board_sum | input | 32*N_BOARDS | Board sums, board i in bits 32*i+31 down to 32*i |
| board_en | input | N_BOARDS | Per-board enable mask |
| remote_sum | input | 32 | Sum received from the remote crate |
| remote_en | input | 1 | Adds the remote term when high |
| remote_dly | input | DLY_W | Alignment delay for the remote sum, in cycles |
| threshold | input | 32 | Trigger threshold |
| holdoff | input | HOLD_W | Dead cycles after each trigger |
| pre_depth | input | clog2(WIN_LEN) | Samples kept before the triggering sample |
| cap_rearm | input | 1 | Releases a held window and re-arms capture |
| rd_idx | input | clog2(WIN_LEN) | Window read index |
| rd_data | output | 32 | Window sample at `rd_idx`, one cycle later |
| global_sum | output | 32 | Registered global sum |
| trig | output | 1 | Trigger pulse |
| cap_done | output | 1 | A captured window is held for reading |
| miss_cnt | output | MISS_W | Triggers not captured |

## Verification
The bench builds the block with N_BOARDS = 4, HIST_DEPTH = 16 and WIN_LEN = 8. With only four boards, a table of board patterns can cover masking and saturation. The 16-entry history wraps many times during a short run, so the window start address is tested across the wrap. The 8-sample window fills in a few cycles, so a second crossing can land while the window is held, and the exact cycle at which `cap_done` rises can be checked directly.

// File: rtl/esum_pkg.sv
package esum_pkg;
  parameter int unsigned ESUM_W = 32;

  typedef logic [ESUM_W-1:0] esum_t;

  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_POST,
    CAP_HELD
  } cap_state_e;

  // Unsigned add that clamps at all-ones instead of wrapping.
  function automatic esum_t sat_add(input esum_t a, input esum_t b);
    logic [ESUM_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[ESUM_W] ? '1 : wide[ESUM_W-1:0];
  endfunction
endpackage

// File: rtl/esum_adder.sv
module esum_adder
  import esum_pkg::*;
#(
  parameter int N_BOARDS = 16,
  parameter int DLY_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_BOARDS*ESUM_W-1:0]   board_sum,
  input  logic [N_BOARDS-1:0]          board_en,
  input  esum_t                        remote_sum,
  input  logic                         remote_en,
  input  logic [DLY_W-1:0]             remote_dly,
  output esum_t                        global_sum
);
  localparam int DLY_N = 1 << DLY_W;

  esum_t dl   [DLY_N-1];
  esum_t taps [DLY_N];
  esum_t local_acc;
  esum_t remote_term;

  assign taps[0] = remote_sum;
  for (genvar g = 1; g < DLY_N; g++) begin : g_tap
    assign taps[g] = dl[g-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY_N-1; i++) dl[i] <= '0;
    end else begin
      dl[0] <= remote_sum;
      for (int i = 1; i < DLY_N-1; i++) dl[i] <= dl[i-1];
    end
  end

  always_comb begin
    local_acc = '0;
    for (int i = 0; i < N_BOARDS; i++) begin
      if (board_en[i]) local_acc = sat_add(local_acc, board_sum[i*ESUM_W +: ESUM_W]);
    end
    remote_term = remote_en ? taps[remote_dly] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) global_sum <= '0;
    else        global_sum <= sat_add(local_acc, remote_term);
  end
endmodule

// File: rtl/esum_thresh.sv
module esum_thresh
  import esum_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  esum_t             global_sum,
  input  esum_t             threshold,
  input  logic [HOLD_W-1:0] holdoff,
  output logic              trig_fire,
  output logic              trig
);
  logic              above;
  logic              above_q;
  logic [HOLD_W-1:0] hold_cnt;

  assign above     = global_sum > threshold;
  assign trig_fire = above && !above_q && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      above_q  <= 1'b0;
      trig     <= 1'b0;
      hold_cnt <= '0;
    end else begin
      above_q <= above;
      trig    <= trig_fire;
      if (trig_fire)            hold_cnt <= holdoff;
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/esum_history.sv
module esum_history
  import esum_pkg::*;
#(
  parameter int HIST_DEPTH = 512,
  parameter int WIN_LEN    = 500,
  parameter int MISS_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  esum_t                      sample,
  input  logic                       trig_fire,
  input  logic [$clog2(WIN_LEN)-1:0] pre_depth,
  input  logic                       cap_rearm,
  input  logic [$clog2(WIN_LEN)-1:0] rd_idx,
  output esum_t                      rd_data,
  output logic                       cap_done,
  output logic [MISS_W-1:0]          miss_cnt
);
  localparam int HA_W = $clog2(HIST_DEPTH);
  localparam int WI_W = $clog2(WIN_LEN);
  localparam logic [WI_W-1:0] WIN_LAST = WI_W'(WIN_LEN - 1);

  esum_t            mem [HIST_DEPTH];
  logic [HA_W-1:0]  wr_ptr;
  logic [HA_W-1:0]  start;
  logic [WI_W-1:0]  post_cnt;
  logic [WI_W-1:0]  pre_eff;
  logic [WI_W-1:0]  post_len;
  logic             wr_en;
  cap_state_e       state;

  assign pre_eff  = (pre_depth > WIN_LAST) ? WIN_LAST : pre_depth;
  assign post_len = WIN_LAST - pre_eff;
  assign wr_en    = (state != CAP_HELD);
  assign cap_done = (state == CAP_HELD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST_DEPTH; i++) mem[i] <= '0;
      wr_ptr   <= '0;
      start    <= '0;
      post_cnt <= '0;
      state    <= CAP_IDLE;
      miss_cnt <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_en) begin
        mem[wr_ptr] <= sample;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      case (state)
        CAP_IDLE: if (trig_fire) begin
          start <= wr_ptr - HA_W'(pre_eff);
          if (post_len == '0) state <= CAP_HELD;
          else begin
            state    <= CAP_POST;
            post_cnt <= post_len;
          end
        end
        CAP_POST: begin
          post_cnt <= post_cnt - 1'b1;
          if (post_cnt == WI_W'(1)) state <= CAP_HELD;
        end
        CAP_HELD: if (cap_rearm) state <= CAP_IDLE;
        default:  state <= CAP_IDLE;
      endcase
      if (trig_fire && (state != CAP_IDLE) && (miss_cnt != '1))
        miss_cnt <= miss_cnt + 1'b1;
      rd_data <= mem[start + HA_W'(rd_idx)];
    end
  end
endmodule

// File: rtl/esum_trigger.sv
module esum_trigger
  import esum_pkg::*;
#(
  parameter int N_BOARDS   = 16,
  parameter int DLY_W      = 4,
  parameter int HOLD_W     = 16,
  parameter int HIST_DEPTH = 512,
  parameter int WIN_LEN    = 500,
  parameter int MISS_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_BOARDS*ESUM_W-1:0]   board_sum,
  input  logic [N_BOARDS-1:0]          board_en,
  input  logic [ESUM_W-1:0]            remote_sum,
  input  logic                         remote_en,
  input  logic [DLY_W-1:0]             remote_dly,
  input  logic [ESUM_W-1:0]            threshold,
  input  logic [HOLD_W-1:0]            holdoff,
  input  logic [$clog2(WIN_LEN)-1:0]   pre_depth,
  input  logic                         cap_rearm,
  input  logic [$clog2(WIN_LEN)-1:0]   rd_idx,
  output logic [ESUM_W-1:0]            rd_data,
  output logic [ESUM_W-1:0]            global_sum,
  output logic                         trig,
  output logic                         cap_done,
  output logic [MISS_W-1:0]            miss_cnt
);
  logic trig_fire;

  esum_adder #(.N_BOARDS(N_BOARDS), .DLY_W(DLY_W)) u_adder (
    .clk, .rst_n, .board_sum, .board_en, .remote_sum, .remote_en,
    .remote_dly, .global_sum
  );

  esum_thresh #(.HOLD_W(HOLD_W)) u_thresh (
    .clk, .rst_n, .global_sum, .threshold, .holdoff, .trig_fire, .trig
  );

  esum_history #(.HIST_DEPTH(HIST_DEPTH), .WIN_LEN(WIN_LEN), .MISS_W(MISS_W)) u_hist (
    .clk, .rst_n, .sample(global_sum), .trig_fire, .pre_depth, .cap_rearm,
    .rd_idx, .rd_data, .cap_done, .miss_cnt
  );
endmodule

// File: rtl/esum_trigger_chk.sv
module esum_trigger_chk #(
  parameter int SUM_W  = 32,
  parameter int HOLD_W = 16,
  parameter int WI_W   = 9,
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SUM_W-1:0]  board0_sum,
  input logic              board0_en,
  input logic [SUM_W-1:0]  global_sum,
  input logic [SUM_W-1:0]  threshold,
  input logic [HOLD_W-1:0] holdoff,
  input logic              trig,
  input logic              cap_done,
  input logic              cap_rearm,
  input logic [WI_W-1:0]   rd_idx,
  input logic [SUM_W-1:0]  rd_data,
  input logic [MISS_W-1:0] miss_cnt
);
  logic            live;
  logic            seen;
  logic [HOLD_W:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= 1'b0;
      seen  <= 1'b0;
      since <= '0;
    end else begin
      live <= 1'b1;
      if (trig) begin
        seen  <= 1'b1;
        since <= (HOLD_W+1)'(1);
      end else if (since != '1) begin
        since <= since + 1'b1;
      end
    end
  end

  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(board0_en) |-> global_sum >= $past(board0_sum));

  p_trig_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && trig |-> $past(global_sum) > $past(threshold));

  p_trig_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  p_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig && seen |-> since > {1'b0, holdoff});

  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && cap_rearm |=> !cap_done);

  p_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live && !trig |-> $stable(miss_cnt));

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(cap_done) && cap_done && $stable(rd_idx) |=> $stable(rd_data));
endmodule

bind esum_trigger esum_trigger_chk #(
  .SUM_W(esum_pkg::ESUM_W), .HOLD_W(HOLD_W), .WI_W($clog2(WIN_LEN)), .MISS_W(MISS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .board0_sum(board_sum[esum_pkg::ESUM_W-1:0]), .board0_en(board_en[0]),
  .global_sum(global_sum), .threshold(threshold), .holdoff(holdoff),
  .trig(trig), .cap_done(cap_done), .cap_rearm(cap_rearm),
  .rd_idx(rd_idx), .rd_data(rd_data), .miss_cnt(miss_cnt)
);

// File: tb/tb_esum_trigger.sv
module tb_esum_trigger;
  localparam int NB = 4;
  localparam int WL = 8;
  localparam int WW = $clog2(WL);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*32-1:0] board_sum = '0;
  logic [NB-1:0]   board_en = '0;
  logic [31:0]     remote_sum = '0;
  logic            remote_en = 1'b0;
  logic [3:0]      remote_dly = '0;
  logic [31:0]     threshold = '1;
  logic [15:0]     holdoff = '0;
  logic [WW-1:0]   pre_depth = '0;
  logic            cap_rearm = 1'b0;
  logic [WW-1:0]   rd_idx = '0;
  logic [31:0]     rd_data, global_sum;
  logic            trig, cap_done;
  logic [15:0]     miss_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  esum_trigger #(.N_BOARDS(NB), .HIST_DEPTH(16), .WIN_LEN(WL)) dut (
    .clk, .rst_n, .board_sum, .board_en, .remote_sum, .remote_en, .remote_dly,
    .threshold, .holdoff, .pre_depth, .cap_rearm, .rd_idx, .rd_data,
    .global_sum, .trig, .cap_done, .miss_cnt
  );

  typedef struct packed {
    logic [31:0] b3, b2, b1, b0;
    logic [3:0]  en;
    logic [31:0] exp;
  } vec_t;

  // R1, R2, R3: board patterns and expected saturating sums
  localparam vec_t TBL [6] = '{
    '{32'd4,   32'd3,   32'd2,   32'd1,          4'hF, 32'd10},
    '{32'd400, 32'd300, 32'd200, 32'd100,        4'h5, 32'd400},
    '{32'd0,   32'd0,   32'd0,   32'd0,          4'hF, 32'd0},
    '{32'd0,   32'd0,   32'h20,  32'hFFFF_FFF0,  4'h3, 32'hFFFF_FFFF},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 4'hF, 32'hFFFF_FFFF},
    '{32'd7,   32'd7,   32'd7,   32'd7,          4'h0, 32'd0}
  };

  localparam logic [31:0] SEQ [16] = '{
    32'd10, 32'd20, 32'd30, 32'd40, 32'd150, 32'd160, 32'd50, 32'd120,
    32'd60, 32'd70, 32'd80, 32'd90, 32'd95, 32'd130, 32'd20, 32'd20
  };
  localparam logic [31:0] WIN [8] = '{
    32'd20, 32'd30, 32'd40, 32'd150, 32'd160, 32'd50, 32'd120, 32'd60
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(global_sum == 0, "R11 global_sum", global_sum, 0);
    chk(trig == 0, "R11 trig", {31'd0, trig}, 0);
    chk(cap_done == 0, "R11 cap_done", {31'd0, cap_done}, 0);
    chk(miss_cnt == 0, "R11 miss_cnt", {16'd0, miss_cnt}, 0);
    rst_n = 1'b1;

    // R1 R2 R3 table walk
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      board_sum = {TBL[i].b3, TBL[i].b2, TBL[i].b1, TBL[i].b0};
      board_en  = TBL[i].en;
      @(negedge clk);
      chk(global_sum == TBL[i].exp, "R1/R2/R3 table", global_sum, TBL[i].exp);
    end

    // R4 remote, zero delay
    @(negedge clk);
    board_sum = {32'd0, 32'd0, 32'd0, 32'd5};
    board_en = 4'h1;
    remote_en = 1'b1; remote_dly = 4'd0; remote_sum = 32'd7;
    @(negedge clk);
    chk(global_sum == 32'd12, "R4 dly0", global_sum, 32'd12);
    // R4 remote disabled contributes zero
    remote_en = 1'b0; remote_sum = 32'd99;
    @(negedge clk);
    chk(global_sum == 32'd5, "R4 disabled", global_sum, 32'd5);
    // R4 delay of 3
    board_en = 4'h0; remote_sum = 32'd0; remote_en = 1'b1; remote_dly = 4'd3;
    repeat (20) @(negedge clk);
    remote_sum = 32'd50;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      remote_sum = 32'd0;
      chk(global_sum == ((k == 4) ? 32'd50 : 32'd0), "R4 dly3", global_sum,
          (k == 4) ? 32'd50 : 32'd0);
    end
    remote_en = 1'b0;

    // R5 R7 R8 R9 R10 trigger and capture
    board_sum = '0; board_en = 4'h1;
    threshold = 32'd100; holdoff = 16'd5; pre_depth = 3'd3;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 16; n++) begin
      chk(trig == ((n == 6) || (n == 15)), "R5/R7 trig", {31'd0, trig},
          {31'd0, ((n == 6) || (n == 15))});
      if (n == 9)  chk(cap_done == 0, "R9 not yet", {31'd0, cap_done}, 0);
      if (n == 10) chk(cap_done == 1, "R9 rise", {31'd0, cap_done}, 1);
      board_sum[31:0] = SEQ[n];
      @(negedge clk);
    end
    chk(miss_cnt == 16'd1, "R10 miss", {16'd0, miss_cnt}, 1);
    chk(cap_done == 1, "R9 held", {31'd0, cap_done}, 1);
    for (int i = 0; i < WL; i++) begin
      rd_idx = WW'(i);
      @(negedge clk);
      chk(rd_data == WIN[i], "R8/R10 window", rd_data, WIN[i]);
    end
    cap_rearm = 1'b1;
    @(negedge clk);
    cap_rearm = 1'b0;
    chk(cap_done == 0, "R9 rearm", {31'd0, cap_done}, 0);

    // R6 equality and staying above
    repeat (8) @(negedge clk);
    for (int n = 0; n < 7; n++) begin
      chk(trig == (n == 4), "R6 trig", {31'd0, trig}, {31'd0, (n == 4)});
      board_sum[31:0] = (n < 2) ? 32'd100 : 32'd101;
      @(negedge clk);
    end

    summary();
    $finish;
  end
endmodule